// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block holds the program counter of a 32-bit RISC core whose instructions are four bytes long and word aligned. Each cycle it looks at the current instruction word and works out where the next fetch comes from. The incoming 32-bit word selects one of three ways of forming an address. A conditional branch adds a signed word offset to the incremented PC. A jump keeps the top bits of the incremented PC and replaces the rest with a 26-bit word index. A register jump takes a whole 32-bit address from an operand.

The core feeds in the two values that a conditional branch compares and the register value for a register jump. The block returns the next PC, a flag that says the flow left sequential order, the return address with a write strobe for the link register, and a flag for a target that is not word aligned. A stall input freezes the PC register. Register reads, arithmetic, instruction memory and hazard handling belong to other blocks.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC register is loaded with `RESET_PC` (default 0x00400000).
- R2: For any instruction that is not a control transfer, and for a branch whose condition fails, `next_pc` is `pc + 4` and `taken` is 0.
- R3: Opcode bits [31:26] = 000100 is branch-if-equal. When `cmp_a == cmp_b`, `next_pc` is `pc + 4 + (sign-extended bits [15:0] << 2)` and `taken` is 1. At PC 0x4000000C an offset of 2 gives 0x40000018.
- R4: Opcode 000101 is branch-if-different. It uses the same target as R3 and is taken only when `cmp_a != cmp_b`.
- R5: Opcode 000010 is a jump. `next_pc` is bits [31:28] of `pc + 4`, then instruction bits [25:0], then two zero bits. `taken` is 1.
- R6: Opcode 000011 is jump-and-link. It uses the R5 target and raises `link_we`. `link_addr` always equals `pc + 4`, and `link_we` is 0 for every other instruction.
- R7: Opcode 000000 with function bits [5:0] = 001000 is a register jump. `next_pc` equals `jr_target` and `taken` is 1. Opcode 000000 with any other function code is sequential.
- R8: Out of reset, the PC register loads `next_pc` at each rising edge where `stall` is 0. It keeps its value at each edge where `stall` is 1.
- R9: `misalign` is 1 exactly when bits [1:0] of `next_pc` are not 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Holds the PC register when high |
| instr | input | 32 | Instruction word at the current PC |
| cmp_a | input | 32 | First branch comparison operand |
| cmp_b | input | 32 | Second branch comparison operand |
| jr_target | input | 32 | Register value used by a register jump |
| pc | output | 32 | Current PC register |
| next_pc | output | 32 | Address of the next fetch |
| taken | output | 1 | Control transfer in effect |
| link_addr | output | 32 | Return address (`pc + 4`) |
| link_we | output | 1 | Write strobe for the link register |
| misalign | output | 1 | `next_pc` is not word aligned |

## Verification
The bench builds the block with its default values: a 32-bit word and a reset address of 0x00400000. With this setup every one of the 65536 branch offsets can be swept in both branch kinds. Jump index fields are walked one bit at a time, and every opcode and every function code for opcode zero is tried. The PC is placed through register jumps next to the top of a 256 MB region and next to the top of the address space. This brings the region carry of the jump target and the 32-bit wrap of the branch target within reach.

// File: rtl/npc_pkg.sv
// Shared definitions for the next-PC unit.
// Assumes the fixed 32-bit instruction layout: opcode in [31:26],
// function code in [5:0], word index in [25:0], offset in [15:0].
package npc_pkg;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BEQ,
        FLOW_BNE,
        FLOW_JMP,
        FLOW_JAL,
        FLOW_JREG
    } flow_e;

    localparam int OP_W    = 6;
    localparam int FUNCT_W = 6;
    localparam int IDX_W   = 26;
    localparam int OFF_W   = 16;

    localparam logic [OP_W-1:0]    OPC_SPECIAL = 6'b000000;
    localparam logic [OP_W-1:0]    OPC_JMP     = 6'b000010;
    localparam logic [OP_W-1:0]    OPC_JAL     = 6'b000011;
    localparam logic [OP_W-1:0]    OPC_BEQ     = 6'b000100;
    localparam logic [OP_W-1:0]    OPC_BNE     = 6'b000101;
    localparam logic [FUNCT_W-1:0] FN_JREG     = 6'b001000;

endpackage

// File: rtl/npc_decode.sv
// Turns opcode and function code into a control-flow class.
// Purely combinational. Every code it does not know counts as sequential.
module npc_decode
    import npc_pkg::*;
(
    input  logic [OP_W-1:0]    opcode,
    input  logic [FUNCT_W-1:0] funct,
    output flow_e              flow
);

    // Map the opcode, and the function code for opcode zero, to a class.
    always_comb begin
        flow = FLOW_SEQ;
        unique case (opcode)
            OPC_BEQ:     flow = FLOW_BEQ;
            OPC_BNE:     flow = FLOW_BNE;
            OPC_JMP:     flow = FLOW_JMP;
            OPC_JAL:     flow = FLOW_JAL;
            OPC_SPECIAL: flow = (funct == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
            default:     flow = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
// Builds the three candidate addresses from the current PC: the
// sequential one, the PC-relative branch target and the region jump.
// Assumes XLEN exceeds IDX_W + 2. All sums wrap modulo 2^XLEN.
module npc_target
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IDX_W-1:0] index,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  br_pc,
    output logic [XLEN-1:0]  jmp_pc
);

    localparam int REGION_W = XLEN - IDX_W - 2;
    localparam int SEXT_W   = XLEN - OFF_W - 2;

    logic [OFF_W-1:0] offset;
    logic [XLEN-1:0]  byte_off;

    // Step past the current word, then add the scaled signed branch offset.
    always_comb begin
        offset   = index[OFF_W-1:0];
        byte_off = {{SEXT_W{offset[OFF_W-1]}}, offset, 2'b00};
        seq_pc   = pc + XLEN'(4);
        br_pc    = seq_pc + byte_off;
    end

    // Keep the region bits of the incremented PC and replace the rest with the word index.
    always_comb begin
        jmp_pc = {seq_pc[XLEN-1 -: REGION_W], index, 2'b00};
    end

endmodule

// File: rtl/npc_select.sv
// Chooses the next PC from the candidate addresses. It resolves the
// branch condition and raises the taken and link-write strobes.
module npc_select
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  flow_e           flow,
    input  logic [XLEN-1:0] cmp_a,
    input  logic [XLEN-1:0] cmp_b,
    input  logic [XLEN-1:0] jr_target,
    input  logic [XLEN-1:0] seq_pc,
    input  logic [XLEN-1:0] br_pc,
    input  logic [XLEN-1:0] jmp_pc,
    output logic [XLEN-1:0] next_pc,
    output logic            taken,
    output logic            link_we
);

    logic same;

    // Compare the operands once and pick the address for this class.
    always_comb begin
        same    = (cmp_a == cmp_b);
        next_pc = seq_pc;
        taken   = 1'b0;
        link_we = 1'b0;
        case (flow)
            FLOW_BEQ: begin
                taken   = same;
                next_pc = same ? br_pc : seq_pc;
            end
            FLOW_BNE: begin
                taken   = !same;
                next_pc = same ? seq_pc : br_pc;
            end
            FLOW_JMP: begin
                taken   = 1'b1;
                next_pc = jmp_pc;
            end
            FLOW_JAL: begin
                taken   = 1'b1;
                link_we = 1'b1;
                next_pc = jmp_pc;
            end
            FLOW_JREG: begin
                taken   = 1'b1;
                next_pc = jr_target;
            end
            default: begin
                taken   = 1'b0;
                next_pc = seq_pc;
            end
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
// Next-PC unit: holds the PC register and computes the next fetch
// address for sequential flow, PC-relative branches, region jumps and
// register jumps. Assumes a synchronous active-low reset and one
// instruction per cycle. A stall freezes the PC.
module npc_unit
    import npc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] cmp_a,
    input  logic [XLEN-1:0] cmp_b,
    input  logic [XLEN-1:0] jr_target,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] next_pc,
    output logic            taken,
    output logic [XLEN-1:0] link_addr,
    output logic            link_we,
    output logic            misalign
);

    flow_e           flow;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] jmp_pc;

    npc_decode u_decode (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .flow   (flow)
    );

    npc_target #(.XLEN(XLEN)) u_target (
        .pc     (pc),
        .index  (instr[IDX_W-1:0]),
        .seq_pc (seq_pc),
        .br_pc  (br_pc),
        .jmp_pc (jmp_pc)
    );

    npc_select #(.XLEN(XLEN)) u_select (
        .flow      (flow),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .jr_target (jr_target),
        .seq_pc    (seq_pc),
        .br_pc     (br_pc),
        .jmp_pc    (jmp_pc),
        .next_pc   (next_pc),
        .taken     (taken),
        .link_we   (link_we)
    );

    // Return address and alignment flag for the chosen target.
    always_comb begin
        link_addr = seq_pc;
        misalign  = (next_pc[1:0] != 2'b00);
    end

    // PC register: reset to the text start, hold on stall, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_PC;
        end else if (!stall) begin
            pc <= next_pc;
        end
    end

endmodule

// File: rtl/npc_unit_chk.sv
// Property checker for npc_unit, attached through bind below.
// Relates the PC register, the next-PC outputs and the decoded fields over time.
module npc_unit_chk #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall,
    input logic [5:0]      op,
    input logic [5:0]      fn,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] next_pc,
    input logic            taken,
    input logic [XLEN-1:0] link_addr,
    input logic            link_we,
    input logic            misalign
);

    // R1: at the first edge after reset is released, the PC holds the reset address
    a_r1_reset_pc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pc == RESET_PC);

    // R8: a stalled edge leaves the PC unchanged
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc));

    // R8: an unstalled edge loads the previous next_pc
    a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> pc == $past(next_pc));

    // R2: without a transfer, the next PC equals the return address
    a_r2_seq_is_link: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> next_pc == link_addr);

    // R6: a link write happens only for a taken jump-and-link
    a_r6_link_taken: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (taken && op == 6'b000011));

    // R9: only a register jump can produce an unaligned target from an aligned PC
    a_r9_misalign_src: assert property (@(posedge clk) disable iff (!rst_n)
        (misalign && pc[1:0] == 2'b00) |-> (op == 6'b000000 && fn == 6'b001000));

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .op        (instr[31:26]),
    .fn        (instr[5:0]),
    .pc        (pc),
    .next_pc   (next_pc),
    .taken     (taken),
    .link_addr (link_addr),
    .link_we   (link_we),
    .misalign  (misalign)
);

// File: tb/npc_unit_test.sv
// Self-checking bench for npc_unit with default parameters.
module npc_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall;
    logic [31:0] instr;
    logic [31:0] cmp_a;
    logic [31:0] cmp_b;
    logic [31:0] jr_target;
    logic [31:0] pc;
    logic [31:0] next_pc;
    logic        taken;
    logic [31:0] link_addr;
    logic        link_we;
    logic        misalign;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    npc_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .instr     (instr),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .jr_target (jr_target),
        .pc        (pc),
        .next_pc   (next_pc),
        .taken     (taken),
        .link_addr (link_addr),
        .link_we   (link_we),
        .misalign  (misalign)
    );

    // 250 MHz clock
    always #2 clk = ~clk;

    // Reference next address from the requirements
    function automatic logic [31:0] ref_next(input logic [31:0] p, input logic [31:0] w,
                                             input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] r);
        logic [31:0] s;
        logic [31:0] off;
        s   = p + 32'd4;
        off = {{14{w[15]}}, w[15:0], 2'b00};
        case (w[31:26])
            6'b000100: return (a == b) ? s + off : s;
            6'b000101: return (a != b) ? s + off : s;
            6'b000010, 6'b000011: return {s[31:28], w[25:0], 2'b00};
            6'b000000: return (w[5:0] == 6'b001000) ? r : s;
            default:   return s;
        endcase
    endfunction

    function automatic logic ref_taken(input logic [31:0] w, input logic [31:0] a,
                                       input logic [31:0] b);
        case (w[31:26])
            6'b000100: return a == b;
            6'b000101: return a != b;
            6'b000010, 6'b000011: return 1'b1;
            6'b000000: return w[5:0] == 6'b001000;
            default:   return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one instruction with PC held and compare all combinational outputs
    task automatic apply(input string req, input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] r);
        logic [31:0] e;
        instr = w; cmp_a = a; cmp_b = b; jr_target = r;
        #1;
        e = ref_next(pc, w, a, b, r);
        check(req, {next_pc, taken, link_we, link_addr, misalign},
              {e, ref_taken(w, a, b), w[31:26] == 6'b000011, pc + 32'd4, e[1:0] != 2'b00});
    endtask

    // Move the PC to any address with a register jump
    task automatic set_pc(input logic [31:0] p);
        @(negedge clk);
        stall = 1'b0; instr = 32'h0000_0008; jr_target = p;
        @(negedge clk);
        stall = 1'b1;
        check("R8", pc, p);
    endtask

    initial begin
        logic [31:0] pcs [5];
        pcs[0] = 32'h4000_000C; pcs[1] = 32'h0FFF_FFFC; pcs[2] = 32'hFFFF_FFFC;
        pcs[3] = 32'h0040_0000; pcs[4] = 32'h7FFF_0000;

        rst_n = 1'b0; stall = 1'b0; instr = 32'h0; cmp_a = 0; cmp_b = 0; jr_target = 0;
        repeat (3) @(negedge clk);
        check("R1", pc, 32'h0040_0000);
        rst_n = 1'b1;
        #1;
        check("R2", {next_pc, taken}, {32'h0040_0004, 1'b0});
        @(negedge clk);
        check("R8", pc, 32'h0040_0004);

        // R3 worked example
        set_pc(32'h4000_000C);
        apply("R3", 32'h1005_0002, 32'd7, 32'd7, 0);
        check("R3", next_pc, 32'h4000_0018);

        // R3 and R4: every offset, taken and not taken
        for (int o = 0; o < 65536; o++) begin
            apply("R3", {6'b000100, 10'h0A5, o[15:0]}, 32'h55, 32'h55, 0);
            apply("R4", {6'b000101, 10'h0A5, o[15:0]}, 32'h55, 32'h54, 0);
        end

        for (int k = 0; k < 5; k++) begin
            set_pc(pcs[k]);
            // R3 / R4 boundary offsets and failing conditions (R2)
            apply("R3", 32'h1000_7FFF, 1, 1, 0);
            apply("R3", 32'h1000_8000, 1, 1, 0);
            apply("R3", 32'h1000_FFFF, 1, 1, 0);
            apply("R2", 32'h1000_0010, 1, 2, 0);
            apply("R4", 32'h1400_8000, 3, 4, 0);
            apply("R2", 32'h1400_0010, 9, 9, 0);
            // R5 / R6: walking index bits, zero and all ones
            for (int i = 0; i < 26; i++) begin
                apply("R5", {6'b000010, 26'(1) << i}, 0, 0, 0);
                apply("R6", {6'b000011, 26'(1) << i}, 0, 0, 0);
            end
            apply("R5", {6'b000010, 26'h0}, 0, 0, 0);
            apply("R6", {6'b000011, 26'h3FF_FFFF}, 0, 0, 0);
            // R7 / R9: register jumps, aligned and not
            for (int m = 0; m < 4; m++) begin
                apply("R7", 32'h03E0_0008, 0, 0, 32'h8765_4320 | m);
                apply("R9", 32'h03E0_0008, 0, 0, 32'h0000_1000 | m);
            end
        end

        // R2: every non-control opcode
        for (int op = 0; op < 64; op++) begin
            if (op != 0 && op != 2 && op != 3 && op != 4 && op != 5)
                apply("R2", {op[5:0], 26'h2AA_AA55}, 5, 5, 32'h1);
        end
        // R7: opcode zero with every function code
        for (int f = 0; f < 64; f++) begin
            apply("R7", {6'b000000, 20'hABCDE, f[5:0]}, 0, 0, 32'h1234_5678);
        end

        // R8: stalled edges keep the PC even under a jump
        set_pc(32'h1000_0000);
        instr = {6'b000010, 26'h000_0100};
        repeat (3) @(negedge clk);
        check("R8", pc, 32'h1000_0000);
        stall = 1'b0;
        @(negedge clk);
        check("R5", pc, 32'h1000_0400);
        // R6: link address after the move
        stall = 1'b1;
        instr = {6'b000011, 26'h000_0040};
        #1;
        check("R6", {link_addr, link_we}, {32'h1000_0404, 1'b1});

        // R1: reset again while running
        stall = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R1", pc, 32'h0040_0000);
        rst_n = 1'b1;

        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (done);
            begin
                #760000;
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule